// File: doc/BRIEF.md
# Ping-Pong Audio Output DMA

This engine feeds a sound codec with stereo 16-bit samples taken from two equal-sized playback buffers in system memory that are used in turn. Software programs a base address and a buffer size through a byte-wide register port. It then sets the enable bit of the output control register. From that point each codec request for data is answered one cycle later with a grant: a memory read address and a byte length. The same cycle also raises a read request toward memory for that range.

When a buffer has been fully handed out, the engine sets a per-buffer drained flag, pulses a drain event and moves to the other buffer. Software refills the drained half while the other one plays. Clearing the enable bit is a soft stop: playback continues until the second buffer has drained. A packed phase register exposes the live byte offset within the active buffer.

Top module: `pingpong_audio_dma`

## Requirements
- R1: The base address is written through register addresses 0..3 (address 0 holds bits 31:24, address 3 bits 7:0), and bits 17:0 always read back as zero.
- R2: The sample count is written at address 4 (high byte) and address 5 (low byte), and its two low bits always read back as zero.
- R3: Buffer 0 starts at base+0x10000 and buffer 1 at base+0x12000. Each buffer holds sample count × 4 bytes. The base and the length are captured when playback starts.
- R4: Writing the output control register (address 6) with bit 0 set while the stored bit 0 is clear starts playback. The position becomes 0, buffer 0 is selected, `playing` rises, and `rate_sel` takes bits 2:1 of the written byte. All registers read 0 after reset.
- R5: A grant carries the length min(requested maximum, bytes left in the active buffer) and the address buffer start + position, and it never crosses a buffer end. A memory request is raised only for a non-zero length.
- R6: A grant that reaches the buffer end sets drained flag N (bit N of address 7, N = active buffer) and pulses `drain_evt[N]`. The position returns to 0 and the other buffer becomes active.
- R7: With bit 0 of the output control register clear, playback continues and stops only when buffer 1 drains; later requests receive `cdc_nodata`.
- R8: The phase register at addresses 8, 9 and 10 (most significant byte first) is 24 bits: six zero bits, the low 12 bits of the byte position, then six zero bits.
- R9: A write to address 7 stores the byte with bits 1:0 forced to zero, and the other bits read back as written. A drain in the same cycle still sets its flag.
- R10: A request while not playing is answered with `cdc_nodata` and no memory request.
- R11: Every grant or no-data answer appears exactly one clock after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cdc_req | input | 1 | Codec asks for data |
| cdc_max | input | MAX_W | Largest byte count the codec accepts |
| cdc_grant | output | 1 | Grant pulse |
| cdc_nodata | output | 1 | No data available pulse |
| cdc_len | output | MAX_W | Granted byte count |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 32 | Memory read address |
| mem_len | output | MAX_W | Memory read length in bytes |
| drain_evt | output | 2 | Per-buffer drain pulse |
| playing | output | 1 | Playback active |
| rate_sel | output | 2 | Sample rate captured at start |

## Verification
A wrong position or buffer select is visible at the first grant that follows it, in `mem_addr` and `cdc_len`. It is also visible in the phase bytes, which the bench reads between requests. A drain taken at the wrong point, or on the wrong buffer, shows up in the same response cycle as a misplaced `drain_evt` bit and a wrong flag at address 7. A faulty soft stop is exposed within one buffer's worth of requests: the stream either ends too early or continues after buffer 1 drains. Random request sizes across several buffer lengths drive the engine through exact-fit, partial and zero-length grants.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

    localparam int AW         = 32;
    localparam int SW         = 16;
    localparam int LW         = SW + 2;
    localparam int ALIGN_BITS = 18;

    localparam logic [AW-1:0] BUF0_OFS = 32'h0001_0000;
    localparam logic [AW-1:0] BUF1_OFS = 32'h0001_2000;

    typedef enum logic [3:0] {
        RA_BASE_B3   = 4'd0,
        RA_BASE_B2   = 4'd1,
        RA_BASE_B1   = 4'd2,
        RA_BASE_B0   = 4'd3,
        RA_SIZE_HI   = 4'd4,
        RA_SIZE_LO   = 4'd5,
        RA_OUT_CTL   = 4'd6,
        RA_DMA_CTL   = 4'd7,
        RA_PHASE_HI  = 4'd8,
        RA_PHASE_MID = 4'd9,
        RA_PHASE_LO  = 4'd10
    } reg_addr_e;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [SW-1:0] size;
        logic [7:0]    out_ctl;
        logic [7:0]    dma_ctl;
    } cfg_t;

    function automatic logic [23:0] phase_word(input logic [LW-1:0] pos);
        return {6'b0, pos[11:0], 6'b0};
    endfunction

endpackage

// File: rtl/ppa_regs.sv
module ppa_regs
    import ppa_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [3:0]    addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic [1:0]    drain_set,
    input  logic [LW-1:0] pos,
    output cfg_t          cfg,
    output logic          start,
    output logic [1:0]    start_rate
);

    cfg_t          cfg_q;
    logic [AW-1:0] base_nx;
    logic [SW-1:0] size_nx;
    logic [23:0]   phase;

    assign cfg        = cfg_q;
    assign start      = we && (addr == RA_OUT_CTL) && wdata[0] && !cfg_q.out_ctl[0];
    assign start_rate = wdata[2:1];
    assign phase      = phase_word(pos);

    always_comb begin
        base_nx = cfg_q.base;
        for (int i = 0; i < 4; i++) begin
            if (addr == 4'(i)) base_nx[8*(3-i) +: 8] = wdata;
        end
        base_nx[ALIGN_BITS-1:0] = '0;
        size_nx = cfg_q.size;
        if (addr == RA_SIZE_HI) size_nx[15:8] = wdata;
        if (addr == RA_SIZE_LO) size_nx[7:0]  = wdata;
        size_nx[1:0] = 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q.dma_ctl[1:0] <= cfg_q.dma_ctl[1:0] | drain_set;
            if (we) begin
                unique case (addr)
                    RA_BASE_B3, RA_BASE_B2, RA_BASE_B1, RA_BASE_B0: cfg_q.base <= base_nx;
                    RA_SIZE_HI, RA_SIZE_LO: cfg_q.size <= size_nx;
                    RA_OUT_CTL: cfg_q.out_ctl <= wdata;
                    RA_DMA_CTL: cfg_q.dma_ctl <= {wdata[7:2], drain_set};
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (addr)
            RA_BASE_B3:   rdata = cfg_q.base[31:24];
            RA_BASE_B2:   rdata = cfg_q.base[23:16];
            RA_BASE_B1:   rdata = cfg_q.base[15:8];
            RA_BASE_B0:   rdata = cfg_q.base[7:0];
            RA_SIZE_HI:   rdata = cfg_q.size[15:8];
            RA_SIZE_LO:   rdata = cfg_q.size[7:0];
            RA_OUT_CTL:   rdata = cfg_q.out_ctl;
            RA_DMA_CTL:   rdata = cfg_q.dma_ctl;
            RA_PHASE_HI:  rdata = phase[23:16];
            RA_PHASE_MID: rdata = phase[15:8];
            RA_PHASE_LO:  rdata = phase[7:0];
            default:      rdata = 8'h00;
        endcase
    end

    // R9: a control write with no drain in flight leaves both flags clear
    a_r9_flags_clear: assert property (@(posedge clk) disable iff (rst)
        (we && addr == RA_DMA_CTL && drain_set == 2'b00) |=> (cfg_q.dma_ctl[1:0] == 2'b00));

    // R1: the stored base stays on a 256 KiB boundary after any write
    a_r1_base_align: assert property (@(posedge clk) disable iff (rst)
        (we && addr <= RA_BASE_B0) |=> (cfg_q.base[ALIGN_BITS-1:0] == '0));

endmodule

// File: rtl/ppa_engine.sv
module ppa_engine
    import ppa_pkg::*;
#(
    parameter int MAX_W = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg,
    input  logic             start,
    input  logic [1:0]       start_rate,
    input  logic             req,
    input  logic [MAX_W-1:0] req_max,
    output logic             grant,
    output logic             nodata,
    output logic [MAX_W-1:0] len,
    output logic             mreq,
    output logic [AW-1:0]    maddr,
    output logic [1:0]       drain_now,
    output logic [1:0]       drain_evt,
    output logic [LW-1:0]    pos,
    output logic             playing,
    output logic [1:0]       rate
);

    logic [LW-1:0]    pos_q, buf_len_q, rem;
    logic [AW-1:0]    addr0_q, addr1_q, cur_base;
    logic             cur_q, play_q;
    logic [MAX_W-1:0] glen;
    logic             at_end, serve;

    assign pos     = pos_q;
    assign playing = play_q;

    always_comb begin
        rem       = buf_len_q - pos_q;
        glen      = (rem < LW'(req_max)) ? rem[MAX_W-1:0] : req_max;
        cur_base  = cur_q ? addr1_q : addr0_q;
        at_end    = (pos_q + LW'(glen)) == buf_len_q;
        serve     = req && play_q && !start;
        drain_now = (serve && at_end) ? (cur_q ? 2'b10 : 2'b01) : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q     <= '0;
            buf_len_q <= '0;
            addr0_q   <= '0;
            addr1_q   <= '0;
            cur_q     <= 1'b0;
            play_q    <= 1'b0;
            rate      <= 2'b00;
            grant     <= 1'b0;
            nodata    <= 1'b0;
            len       <= '0;
            mreq      <= 1'b0;
            maddr     <= '0;
            drain_evt <= 2'b00;
        end else begin
            grant     <= 1'b0;
            nodata    <= 1'b0;
            mreq      <= 1'b0;
            drain_evt <= drain_now;
            if (start) begin
                pos_q     <= '0;
                cur_q     <= 1'b0;
                play_q    <= 1'b1;
                rate      <= start_rate;
                buf_len_q <= {cfg.size, 2'b00};
                addr0_q   <= cfg.base + BUF0_OFS;
                addr1_q   <= cfg.base + BUF1_OFS;
                nodata    <= req;
            end else if (req && !play_q) begin
                nodata <= 1'b1;
            end else if (serve) begin
                grant <= 1'b1;
                len   <= glen;
                mreq  <= (glen != '0);
                maddr <= cur_base + AW'(pos_q);
                if (at_end) begin
                    pos_q <= '0;
                    cur_q <= ~cur_q;
                    if (cur_q && !cfg.out_ctl[0]) play_q <= 1'b0;
                end else begin
                    pos_q <= pos_q + LW'(glen);
                end
            end
        end
    end

    // R5: a grant never exceeds the maximum the codec asked for
    a_r5_len_le_max: assert property (@(posedge clk) disable iff (rst)
        grant |-> (len <= $past(req_max)));

    // R5: the position never passes the end of the buffer
    a_r5_no_cross: assert property (@(posedge clk) disable iff (rst)
        play_q |-> (pos_q <= buf_len_q));

    // R6: at most one buffer drains per response
    a_r6_drain_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drain_evt));

    // R7: playback only ends on the drain of buffer 1
    a_r7_stop_after_b1: assert property (@(posedge clk) disable iff (rst)
        $fell(play_q) |-> drain_evt[1]);

    // R10: idle requests get a no-data answer and no memory traffic
    a_r10_idle_nodata: assert property (@(posedge clk) disable iff (rst)
        (req && !play_q && !start) |=> (nodata && !mreq && !grant));

    // R11: each answer follows a request sampled one cycle earlier
    a_r11_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (grant || nodata) |-> $past(req));

endmodule

// File: rtl/pingpong_audio_dma.sv
module pingpong_audio_dma
    import ppa_pkg::*;
#(
    parameter int MAX_W = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       reg_addr,
    input  logic             reg_we,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             cdc_req,
    input  logic [MAX_W-1:0] cdc_max,
    output logic             cdc_grant,
    output logic             cdc_nodata,
    output logic [MAX_W-1:0] cdc_len,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    output logic [MAX_W-1:0] mem_len,
    output logic [1:0]       drain_evt,
    output logic             playing,
    output logic [1:0]       rate_sel
);

    cfg_t          cfg;
    logic          start;
    logic [1:0]    start_rate;
    logic [1:0]    drain_now;
    logic [LW-1:0] pos;

    ppa_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .drain_set  (drain_now),
        .pos        (pos),
        .cfg        (cfg),
        .start      (start),
        .start_rate (start_rate)
    );

    ppa_engine #(.MAX_W(MAX_W)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .start      (start),
        .start_rate (start_rate),
        .req        (cdc_req),
        .req_max    (cdc_max),
        .grant      (cdc_grant),
        .nodata     (cdc_nodata),
        .len        (cdc_len),
        .mreq       (mem_req),
        .maddr      (mem_addr),
        .drain_now  (drain_now),
        .drain_evt  (drain_evt),
        .pos        (pos),
        .playing    (playing),
        .rate       (rate_sel)
    );

    assign mem_len = cdc_len;

endmodule

// File: tb/pingpong_audio_dma_test.sv
`timescale 1ns/1ps
module pingpong_audio_dma_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        cdc_req = 1'b0;
    logic [7:0]  cdc_max = '0;
    logic        cdc_grant, cdc_nodata, mem_req, playing;
    logic [7:0]  cdc_len, mem_len;
    logic [31:0] mem_addr;
    logic [1:0]  drain_evt, rate_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_base = 0, m_b = 0;
    logic [15:0] m_size = 0;
    logic [7:0]  m_ctl = 0, m_dma = 0;
    int          m_len = 0, m_pos = 0, m_cur = 0;
    bit          m_play = 0;
    logic [1:0]  m_rate = 0;

    always #10 clk = ~clk;

    pingpong_audio_dma uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cdc_req(cdc_req),
        .cdc_max(cdc_max), .cdc_grant(cdc_grant), .cdc_nodata(cdc_nodata),
        .cdc_len(cdc_len), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_len(mem_len), .drain_evt(drain_evt), .playing(playing),
        .rate_sel(rate_sel)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input int cur, input int p);
        return m_b + (cur != 0 ? 32'h0001_2000 : 32'h0001_0000) + 32'(p);
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            4'd0, 4'd1, 4'd2, 4'd3: begin
                m_base[8*(3-a) +: 8] = d;
                m_base[17:0] = '0;
            end
            4'd4: m_size[15:8] = d;
            4'd5: m_size[7:0] = d & 8'hFC;
            4'd6: begin
                if (d[0] && !m_ctl[0]) begin
                    m_pos = 0; m_cur = 0; m_play = 1;
                    m_len = int'(m_size) * 4; m_b = m_base; m_rate = d[2:1];
                end
                m_ctl = d;
            end
            4'd7: m_dma = {d[7:2], 2'b00};
            default: ;
        endcase
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic do_req(input logic [7:0] mx);
        int l;
        logic [1:0] ed;
        @(negedge clk);
        cdc_req = 1'b1; cdc_max = mx;
        @(negedge clk);
        cdc_req = 1'b0;
        if (!m_play) begin
            // R10 and R11: idle request answered after one edge with no data
            check(cdc_nodata && !cdc_grant && !mem_req, "R10 idle nodata",
                  {cdc_nodata, cdc_grant, mem_req}, 3'b100);
        end else begin
            l = m_len - m_pos;
            if (int'(mx) < l) l = int'(mx);
            // R5 and R11: grant content one cycle after the request
            check(cdc_grant && !cdc_nodata && cdc_len == 8'(l) && mem_len == 8'(l),
                  "R5 grant length", {cdc_grant, cdc_nodata, cdc_len}, {2'b10, 8'(l)});
            check(mem_req == (l != 0) && (l == 0 || mem_addr == exp_addr(m_cur, m_pos)),
                  "R3 read address", {mem_req, mem_addr}, {(l != 0), exp_addr(m_cur, m_pos)});
            ed = 2'b00;
            if (m_pos + l == m_len) begin
                ed[m_cur] = 1'b1;
                m_dma[m_cur] = 1'b1;
                if (m_cur == 1 && !m_ctl[0]) m_play = 0;
                m_cur ^= 1;
                m_pos = 0;
            end else begin
                m_pos += l;
            end
            // R6: drain pulse on the buffer that ended
            check(drain_evt == ed, "R6 drain event", drain_evt, ed);
            // R7: playing follows the soft-stop rule
            check(playing == m_play, "R7 playing", playing, m_play);
        end
    endtask

    task automatic chk_phase();
        logic [7:0] b2, b1, b0;
        logic [23:0] e;
        rd(4'd8, b2); rd(4'd9, b1); rd(4'd10, b0);
        e = {6'b0, 12'(m_pos), 6'b0};
        // R8: phase layout, most significant byte first
        check({b2, b1, b0} == e, "R8 phase", {b2, b1, b0}, e);
    endtask

    task automatic chk_flags();
        logic [7:0] d;
        rd(4'd7, d);
        // R6 and R9: drained flags in bits 1:0
        check(d == m_dma, "R6 drained flags", d, m_dma);
    endtask

    task automatic rand_run(input int n, input bit allow_stop);
        for (int i = 0; i < n; i++) begin
            logic [7:0] mx;
            int r;
            r = $urandom % 16;
            mx = (r == 0) ? 8'd0 : (r == 1) ? 8'hFF : 8'($urandom % 48 + 1);
            do_req(mx);
            if ($urandom % 8 == 0) chk_phase();
            if ($urandom % 8 == 0) chk_flags();
            if (allow_stop && $urandom % 40 == 0) wr(4'd6, m_ctl & 8'hFE);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, d1, d2, d3;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R4: reset state
        rd(4'd6, d); check(d == 0, "R4 reset out ctl", d, 0);
        rd(4'd7, d); check(d == 0, "R4 reset dma ctl", d, 0);
        rd(4'd0, d); check(d == 0, "R4 reset base", d, 0);
        check(!playing && drain_evt == 0, "R4 reset idle", {playing, drain_evt}, 0);

        // R1: base alignment
        for (int i = 0; i < 4; i++) wr(4'(i), 8'hFF);
        rd(4'd0, d); rd(4'd1, d1); rd(4'd2, d2); rd(4'd3, d3);
        check({d, d1, d2, d3} == 32'hFFFC_0000, "R1 base align", {d, d1, d2, d3}, 32'hFFFC_0000);

        // R2: size multiple of four
        wr(4'd4, 8'h01); wr(4'd5, 8'h23);
        rd(4'd4, d); rd(4'd5, d1);
        check({d, d1} == 16'h0120, "R2 size", {d, d1}, 16'h0120);

        // R10: idle request
        do_req(8'd16);

        wr(4'd0, 8'h12); wr(4'd1, 8'h37); wr(4'd2, 8'hAB); wr(4'd3, 8'hCD);
        rd(4'd1, d); check(d == 8'h34, "R1 base byte", d, 8'h34);
        wr(4'd4, 8'h00); wr(4'd5, 8'h10);

        // R4: start
        wr(4'd6, 8'h05);
        check(playing && rate_sel == 2'd2, "R4 start", {playing, rate_sel}, 3'b110);
        chk_phase();
        rand_run(300, 1'b0);

        // R9: control write clears flags, other bits kept
        wr(4'd7, 8'hA7);
        rd(4'd7, d); check(d == 8'hA4, "R9 dma ctl write", d, 8'hA4);
        rd(4'd6, d); check(d == m_ctl, "R4 out ctl readback", d, m_ctl);

        // R7: soft stop issued during buffer 0
        wr(4'd6, 8'h00); wr(4'd6, 8'h03);
        check(rate_sel == 2'd1, "R4 restart rate", rate_sel, 2'd1);
        do_req(8'd8);
        wr(4'd6, 8'h02);
        for (int i = 0; i < 8; i++) begin
            check(playing == 1'b1, "R7 still playing", playing, 1'b1);
            do_req(8'd16);
        end
        check(!playing, "R7 stopped after buffer 1", playing, 1'b0);
        do_req(8'd16);
        chk_flags();

        // random buffer lengths with random soft stops and restarts
        for (int k = 0; k < 4; k++) begin
            wr(4'd5, 8'($urandom % 60 + 1) << 2);
            wr(4'd6, 8'h00);
            wr(4'd6, 8'h01 | 8'(($urandom % 4) << 1));
            check(rate_sel == m_rate, "R4 rate", rate_sel, m_rate);
            rand_run(250, 1'b1);
            chk_flags();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule